// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter, four bits wide by default, that advances on the rising clock edge. It has an active-low clear that acts at once and ignores the clock. It also has an active-low parallel preset that takes effect on the clock edge. Two count-enable inputs must both be high for the count to advance. Only the second of them, the chain enable, also qualifies the terminal-count output.

The terminal-count output is high when the count is all ones and the chain enable is high. Several stages can therefore be chained with no glue logic. Each stage's terminal-count output drives the chain enable of the next stage. All stages share the clock, the clear, the preset strobe and the first enable. The first enable is not part of the carry term, so a global pause does not have to ripple through the chain.

Top module: `cascade_counter`

## Requirements
- R1: The count changes only on a rising edge of `clk`. A change of `ld_n`, `din` or the enables between edges leaves `cnt` unchanged.
- R2: While `clr_n` is low, `cnt` is zero. Pulling `clr_n` low forces `cnt` to zero at once, without waiting for a clock edge, whatever the other inputs are.
- R3: With `clr_n` high and `ld_n` low, the next rising edge copies `din` into `cnt`, whatever the enables are. `din[0]` goes to `cnt[0]`, the least significant bit, and `din[W-1]` goes to `cnt[W-1]`.
- R4: With `clr_n` and `ld_n` high and both `en_cnt` and `en_chain` high, each rising edge adds one to `cnt`.
- R5: With `clr_n` and `ld_n` high and either enable low, `cnt` keeps its value across rising edges.
- R6: A counting edge at the all-ones value (15 for W=4) takes `cnt` to zero.
- R7: `tc_out` is high exactly when `en_chain` is high and `cnt` is all ones. It follows without a register delay, and `en_cnt` has no effect on it.
- R8: After `clr_n` returns high between edges, `cnt` stays zero until the next rising edge, and normal operation starts on that edge.
- R9: A chain of stages, with each `tc_out` driving the next stage's `en_chain` and the first stage's `en_chain` tied high, counts as one wide binary counter. It passes from all ones back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel preset, active low |
| en_cnt | input | 1 | Count enable; has no effect on the terminal-count output |
| en_chain | input | 1 | Count enable that also qualifies the terminal-count output |
| din | input | W | Preset value, bit 0 least significant |
| cnt | output | W | Current count |
| tc_out | output | 1 | Terminal count: all ones and `en_chain` high |

## Verification
On every sampled edge, the assertions check the edge-to-edge effect of preset, increment and hold. They check that the count is zero while clear is low and that the terminal-count output agrees with the count and the chain enable. Some behaviour falls between edges, and only the bench's timed scenarios can show it. This includes the immediate effect of clear, the absence of any change when inputs move between edges, and the delay until the first edge after clear is released. Only the bench's two-stage chain can show that stages carry correctly into one another through the full 8-bit range.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_INC  = 2'd2
    } cnt_op_e;

endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
    import cascade_counter_pkg::*;
(
    input  logic    ld_n,
    input  logic    en_cnt,
    input  logic    en_chain,
    output cnt_op_e op
);

    // preset outranks counting; both enables needed to advance
    always_comb begin
        if (!ld_n) begin
            op = OP_LOAD;
        end else if (en_cnt && en_chain) begin
            op = OP_INC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_next.sv
module cnt_next
    import cascade_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  cnt_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);

    logic [W-1:0] inc_val;
    logic [W:0]   ones_below;

    assign ones_below[0] = 1'b1;

    // bit i toggles when every lower bit is one
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign inc_val[i]      = cur[i] ^ ones_below[i];
        assign ones_below[i+1] = ones_below[i] & cur[i];
    end

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_INC:  nxt = inc_val;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         en_chain,
    output logic         tc
);

    logic [W:0] all_ones;

    assign all_ones[0] = en_chain;

    for (genvar i = 0; i < W; i++) begin : g_and
        assign all_ones[i+1] = all_ones[i] & cur[i];
    end

    assign tc = all_ones[W];

endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         en_cnt,
    input  logic         en_chain,
    input  logic [W-1:0] din,
    output logic [W-1:0] cnt,
    output logic         tc_out
);

    typedef struct packed {
        logic [W-1:0] count;
    } state_t;

    state_t       state_d;
    state_t       state_q;
    cnt_op_e      op;
    logic [W-1:0] nxt_count;

    cnt_ctrl u_ctrl (
        .ld_n     (ld_n),
        .en_cnt   (en_cnt),
        .en_chain (en_chain),
        .op       (op)
    );

    cnt_next #(.W(W)) u_next (
        .op  (op),
        .cur (state_q.count),
        .din (din),
        .nxt (nxt_count)
    );

    cnt_carry #(.W(W)) u_carry (
        .cur      (state_q.count),
        .en_chain (en_chain),
        .tc       (tc_out)
    );

    always_comb begin
        state_d       = state_q;
        state_d.count = nxt_count;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt = state_q.count;

endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         ld_n,
    input logic         en_cnt,
    input logic         en_chain,
    input logic [W-1:0] din,
    input logic [W-1:0] cnt,
    input logic         tc_out
);

    AST_CLEAR_ZERO: assert property (@(posedge clk) !clr_n |-> cnt == '0); // R2

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!clr_n)
        !ld_n |=> cnt == $past(din)); // R3

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_cnt && en_chain) |=> cnt == W'($past(cnt) + 1'b1)); // R4

    AST_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && !(en_cnt && en_chain)) |=> $stable(cnt)); // R5

    AST_WRAP: assert property (@(posedge clk) disable iff (!clr_n)
        (ld_n && en_cnt && en_chain && (&cnt)) |=> cnt == '0); // R6

    AST_TC_NEEDS_ONES: assert property (@(posedge clk) disable iff (!clr_n)
        tc_out |-> ((&cnt) && en_chain)); // R7

    AST_TC_PRESENT: assert property (@(posedge clk) disable iff (!clr_n)
        ((&cnt) && en_chain) |-> tc_out); // R7

endmodule

bind cascade_counter cascade_counter_chk #(.W(W)) i_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .ld_n     (ld_n),
    .en_cnt   (en_cnt),
    .en_chain (en_chain),
    .din      (din),
    .cnt      (cnt),
    .tc_out   (tc_out)
);

// File: tb/test_cascade_counter.sv
`timescale 1ns/1ps
module test_cascade_counter;

    localparam int W      = 4;
    localparam int STAGES = 2;
    localparam int CW     = W * STAGES;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         ld_n = 1'b1;
    logic         en_cnt = 1'b0;
    logic         en_chain = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt;
    logic         tc_out;

    logic         ch_ld_n = 1'b0;
    logic         ch_en = 1'b0;
    logic [W-1:0] ch_q  [STAGES];
    logic         ch_tc [STAGES];
    logic         ch_in [STAGES+1];

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cascade_counter #(.W(W)) i_cascade_counter (
        .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_cnt(en_cnt),
        .en_chain(en_chain), .din(din), .cnt(cnt), .tc_out(tc_out)
    );

    assign ch_in[0] = 1'b1;
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        cascade_counter #(.W(W)) i_stage (
            .clk(clk), .clr_n(clr_n), .ld_n(ch_ld_n), .en_cnt(ch_en),
            .en_chain(ch_in[s]), .din('0), .cnt(ch_q[s]), .tc_out(ch_tc[s])
        );
        assign ch_in[s+1] = ch_tc[s];
    end

    function automatic logic [CW-1:0] chain_value();
        logic [CW-1:0] v;
        for (int s = 0; s < STAGES; s++) v[s*W +: W] = ch_q[s];
        return v;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // advance to just after the next rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic preset(input logic [W-1:0] v);
        ld_n = 1'b0;
        din  = v;
        step();
        ld_n = 1'b1;
    endtask

    initial begin
        #1 clr_n = 1'b0;
        #1 chk("R2 clear at start", 32'(cnt), 0);
        step();
        chk("R2 clear holds over edge", 32'(cnt), 0);

        // release between edges with counting enabled
        en_cnt = 1'b1; en_chain = 1'b1;
        clr_n = 1'b1;
        #1 chk("R8 no change before edge", 32'(cnt), 0);
        step();
        chk("R8 counts on first edge", 32'(cnt), 1);

        // preset of every value under every enable pattern
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 4; e++) begin
                en_cnt = e[0]; en_chain = e[1];
                preset(W'(v));
                chk("R3 preset", 32'(cnt), 32'(v));
            end
        end
        en_cnt = 1'b0; en_chain = 1'b0;
        preset(4'b0001);
        chk("R3 din[0] to cnt[0]", 32'(cnt[0]), 1);

        // R1: inputs moved between edges
        ld_n = 1'b0; din = 4'd12;
        #1 chk("R1 no change between edges", 32'(cnt), 1);
        step();
        ld_n = 1'b1;
        chk("R1 takes effect at edge", 32'(cnt), 12);

        // count sweep through wrap
        preset('0);
        en_cnt = 1'b1; en_chain = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            step();
            chk((k == 16) ? "R6 wrap" : "R4 count", 32'(cnt), 32'(k % 16));
        end

        // hold patterns
        for (int e = 0; e < 3; e++) begin
            en_cnt = 1'b0; en_chain = 1'b0;
            preset(4'd5);
            en_cnt = e[0]; en_chain = e[1];
            repeat (3) step();
            chk("R5 hold", 32'(cnt), 5);
        end

        // terminal count for every value and enable pattern
        for (int v = 0; v < 16; v++) begin
            for (int e = 0; e < 4; e++) begin
                preset(W'(v));
                en_cnt = e[0]; en_chain = e[1];
                #1 chk("R7 carry", 32'(tc_out), 32'(e[1] && v == 15));
            end
        end

        // clear acting between edges
        en_cnt = 1'b0; en_chain = 1'b0;
        preset(4'd9);
        clr_n = 1'b0;
        #1 chk("R2 immediate clear", 32'(cnt), 0);
        ld_n = 1'b0; din = 4'd7;
        step();
        chk("R2 clear beats preset", 32'(cnt), 0);
        ld_n = 1'b1;
        clr_n = 1'b1;

        // two-stage chain through full range
        ch_ld_n = 1'b0;
        step();
        ch_ld_n = 1'b1; ch_en = 1'b1;
        for (int k = 1; k <= 260; k++) begin
            step();
            chk("R9 chain", 32'(chain_value()), 32'(k % 256));
        end
        ch_en = 1'b0;
        repeat (2) step();
        chk("R9 chain pause", 32'(chain_value()), 32'(260 % 256));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule